// File: doc/BRIEF.md
# Digital Video Capture Front-End

This block receives one digital YUV 4:2:2 video input and turns it into a stream of pixel pairs. Each pair carries two luma samples and the chroma pair they share (Y0, Y1, Cb, Cr). Line and field timing comes from one of three sources, chosen by a mode input: separate horizontal and vertical sync levels, an active-data qualifier with a vertical sync level, or timing codes embedded in the data itself.

The input bus is either one byte lane, where a pixel pair takes four clocks, or two lanes, where luma and one chroma sample arrive together and a pair takes two clocks. A rectangular crop window then keeps only the pairs inside it. The first kept pair after field blanking carries a start-of-field marker. The kept pair that reaches the window's right edge carries an end-of-line marker. Downstream scalers and memory writers see only the cropped region.

Top module: `vid_capture_frontend`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, `pix_valid`, `pix_sof` and `pix_eol` are 0.
- R2: With `wide_bus`=0 the pair is taken from `din[7:0]` over four active words, in the order Cb, Y0, Cr, Y1.
- R3: With `wide_bus`=1 each active word carries luma on `din[7:0]` and chroma on `din[15:8]`. The first word of a pair holds Cb with Y0 and the second holds Cr with Y1.
- R4: With `sync_mode`=0 (or 3), a word is active when `hsync_in` and `vsync_in` are both 0. `vsync_in`=1 is field blanking. `act_in` is ignored.
- R5: With `sync_mode`=1, a word is active when `act_in`=1 and `vsync_in`=0. `hsync_in` is ignored.
- R6: With `sync_mode`=2, a code is the words FF, 00, 00, XY on `din[7:0]`, where XY bit 7 is 1, bit 5 is V and bit 4 is H. A code with H=0 and V=0 makes the following words active. A word of FF on `din[7:0]` ends the active period at that word.
- R7: With `sync_mode`=2, a code with V=1 starts field blanking. A code with H=0 and V=1 does not make the following words active.
- R8: A pair is kept only if its first pixel index px satisfies even(`win_x0`) <= px < `win_x1`. Bit 0 of `win_x0` is ignored. px counts from 0 at the start of each active line and rises by 2 per pair.
- R9: A pair is kept only if its line index satisfies `win_y0` <= line < `win_y1`. The line index is 0 for the first active line after field blanking and rises by 1 after each active line.
- R10: `pix_sof` is 1 on the first kept pair after field blanking and 0 on later pairs of that field.
- R11: `pix_eol` is 1 on a kept pair when px+2 >= `win_x1`.
- R12: A kept pair is presented for exactly one cycle. It appears in the cycle after the clock edge that samples its last input word, so `pix_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_mode | input | 2 | 0/3 sync levels, 1 qualifier, 2 embedded codes |
| wide_bus | input | 1 | 0 single byte lane, 1 luma plus chroma lanes |
| win_x0 | input | CNT_W | Window left edge, inclusive, forced even |
| win_x1 | input | CNT_W | Window right edge, exclusive |
| win_y0 | input | CNT_W | Window top line, inclusive |
| win_y1 | input | CNT_W | Window bottom line, exclusive |
| din | input | 16 | Video data, luma or byte lane in bits 7:0 |
| hsync_in | input | 1 | Horizontal blanking level (mode 0) |
| vsync_in | input | 1 | Vertical blanking level (modes 0 and 1) |
| act_in | input | 1 | Active-data qualifier (mode 1) |
| pix_valid | output | 1 | Kept pair present this cycle |
| pix_y0 | output | 8 | Luma of the even pixel |
| pix_y1 | output | 8 | Luma of the odd pixel |
| pix_cb | output | 8 | Shared blue-difference chroma |
| pix_cr | output | 8 | Shared red-difference chroma |
| pix_sof | output | 1 | First kept pair of the field |
| pix_eol | output | 1 | Pair reaching the window's right edge |

## Verification
Every kept pair is due exactly one cycle after the edge that samples its final word. That is the fourth active byte on the narrow bus or the second active word on the wide bus. A capture process therefore samples the outputs one time unit after every rising edge and logs each valid pair in arrival order. The log is compared, entry by entry, with a list the bench builds from the window bounds and the data it sent. A dedicated timing scenario steps word by word and checks that the output is still low after the first word of a pair, high after the second, and low again one cycle later.

// File: rtl/vcap_pkg.sv
// Package: shared sample width, sync-mode encoding and the pixel-pair type
// used by every stage of the capture front-end.
package vcap_pkg;

    localparam int SAMPLE_W = 8;

    typedef enum logic [1:0] {
        SYNC_LEVELS = 2'd0,
        SYNC_QUAL   = 2'd1,
        SYNC_CODES  = 2'd2,
        SYNC_ALT    = 2'd3
    } sync_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] y1;
        logic [SAMPLE_W-1:0] y0;
        logic [SAMPLE_W-1:0] cr;
        logic [SAMPLE_W-1:0] cb;
    } pix_pair_t;

endpackage

// File: rtl/vcap_sync_recover.sv
// Timing recovery: decides, word by word, whether the current input word is
// active video and whether the input is in field blanking.
// Assumes: in code mode the preamble value (all ones) never occurs as active
// luma data, so it can close the active period before the status word.
module vcap_sync_recover
    import vcap_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] lane,
    input  logic         hsync,
    input  logic         vsync,
    input  logic         qual,
    output logic         act,
    output logic         vblank
);

    localparam logic [W-1:0] ALL_ONES  = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZEROS = {W{1'b0}};
    localparam int TAG_BIT = W - 1;
    localparam int V_BIT   = W - 3;
    localparam int H_BIT   = W - 4;

    logic [W-1:0] hist0, hist1, hist2;
    logic         code_hit;
    logic         in_act;
    logic         code_vb;
    logic         code_act;
    sync_mode_e   mode_e;

    assign mode_e = sync_mode_e'(mode);

    // Purpose: keep the last three lane words for preamble matching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist0 <= ALL_ZEROS;
            hist1 <= ALL_ZEROS;
            hist2 <= ALL_ZEROS;
        end else begin
            hist2 <= hist1;
            hist1 <= hist0;
            hist0 <= lane;
        end
    end

    // Purpose: flag the status word that completes a timing code.
    always_comb begin
        code_hit = (hist2 == ALL_ONES) && (hist1 == ALL_ZEROS) &&
                   (hist0 == ALL_ZEROS) && lane[TAG_BIT];
    end

    // Purpose: track active period and field blanking from embedded codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_act  <= 1'b0;
            code_vb <= 1'b1;
        end else if (code_hit) begin
            in_act  <= !lane[H_BIT] && !lane[V_BIT];
            code_vb <= lane[V_BIT];
        end else if (lane == ALL_ONES) begin
            in_act  <= 1'b0;
        end
    end

    assign code_act = in_act && (lane != ALL_ONES) && !code_hit;

    // Purpose: select the active and blanking indications for the mode.
    always_comb begin
        case (mode_e)
            SYNC_QUAL: begin
                act    = qual && !vsync;
                vblank = vsync;
            end
            SYNC_CODES: begin
                act    = code_act;
                vblank = code_vb;
            end
            default: begin
                act    = !hsync && !vsync;
                vblank = vsync;
            end
        endcase
    end

endmodule

// File: rtl/vcap_pair_assembler.sv
// Pair assembly: gathers active words into Y0/Y1/Cb/Cr pairs and keeps the
// pixel index within the line and the line index within the field.
// Assumes: each active line starts on a Cb sample (or Cb/Y0 word).
module vcap_pair_assembler
    import vcap_pkg::*;
#(
    parameter int W     = SAMPLE_W,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             act,
    input  logic             vblank,
    input  logic [2*W-1:0]   din,
    output logic             pair_stb,
    output pix_pair_t        pair,
    output logic [CNT_W-1:0] px,
    output logic [CNT_W-1:0] ln
);

    localparam logic [1:0] LAST_NARROW = 2'd3;
    localparam logic [1:0] LAST_WIDE   = 2'd1;

    logic [W-1:0] lo_lane, hi_lane;
    logic [1:0]   phase;
    logic [1:0]   last_phase;
    logic [W-1:0] held_cb, held_y0, held_cr;
    logic         prev_act;
    logic         line_end;

    assign lo_lane    = din[W-1:0];
    assign hi_lane    = din[2*W-1:W];
    assign last_phase = wide ? LAST_WIDE : LAST_NARROW;
    assign pair_stb   = act && (phase == last_phase);
    assign line_end   = prev_act && !act;

    // Purpose: step the word phase and the pixel index along a line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 2'd0;
            px    <= '0;
        end else if (!act) begin
            phase <= 2'd0;
            px    <= '0;
        end else if (phase == last_phase) begin
            phase <= 2'd0;
            px    <= px + CNT_W'(2);
        end else begin
            phase <= phase + 2'd1;
        end
    end

    // Purpose: hold the early samples of a pair until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_cb <= '0;
            held_y0 <= '0;
            held_cr <= '0;
        end else if (act) begin
            if (wide) begin
                if (phase == 2'd0) begin
                    held_cb <= hi_lane;
                    held_y0 <= lo_lane;
                end
            end else begin
                case (phase)
                    2'd0:    held_cb <= lo_lane;
                    2'd1:    held_y0 <= lo_lane;
                    2'd2:    held_cr <= lo_lane;
                    default: ;
                endcase
            end
        end
    end

    // Purpose: form the complete pair from held and current samples.
    always_comb begin
        pair.cb = held_cb;
        pair.y0 = held_y0;
        pair.y1 = lo_lane;
        pair.cr = wide ? hi_lane : held_cr;
    end

    // Purpose: count active lines since field blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act <= 1'b0;
            ln       <= '0;
        end else begin
            prev_act <= act;
            if (vblank) begin
                ln <= '0;
            end else if (line_end) begin
                ln <= ln + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/vcap_window.sv
// Crop window and output register: keeps pairs inside the rectangle, marks
// start of field and end of line, and registers the result.
// Assumes: window bounds are static while a field is captured.
module vcap_window
    import vcap_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_stb,
    input  pix_pair_t        pair,
    input  logic [CNT_W-1:0] px,
    input  logic [CNT_W-1:0] ln,
    input  logic             vblank,
    input  logic [CNT_W-1:0] x0,
    input  logic [CNT_W-1:0] x1,
    input  logic [CNT_W-1:0] y0,
    input  logic [CNT_W-1:0] y1,
    output logic             out_valid,
    output pix_pair_t        out_pair,
    output logic             out_sof,
    output logic             out_eol
);

    logic [CNT_W-1:0] x0_even;
    logic [CNT_W:0]   px_next;
    logic             in_x, in_y, keep;
    logic             sof_armed;

    assign x0_even = {x0[CNT_W-1:1], 1'b0};
    assign px_next = {1'b0, px} + (CNT_W+1)'(2);

    // Purpose: decide whether the completed pair lies inside the window.
    always_comb begin
        in_x = (px >= x0_even) && (px < x1);
        in_y = (ln >= y0) && (ln < y1);
        keep = pair_stb && in_x && in_y;
    end

    // Purpose: arm the start-of-field marker during blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_armed <= 1'b0;
        end else if (vblank) begin
            sof_armed <= 1'b1;
        end else if (keep) begin
            sof_armed <= 1'b0;
        end
    end

    // Purpose: register the kept pair and its markers for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pair  <= '0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_valid <= keep;
            out_sof   <= keep && sof_armed;
            out_eol   <= keep && (px_next >= {1'b0, x1});
            if (keep) begin
                out_pair <= pair;
            end
        end
    end

endmodule

// File: rtl/vid_capture_frontend.sv
// Top: digital video capture front-end. Recovers timing, assembles 4:2:2
// pixel pairs and forwards those inside the crop window.
// Assumes: all inputs are synchronous to clk.
module vid_capture_frontend
    import vcap_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            sync_mode,
    input  logic                  wide_bus,
    input  logic [CNT_W-1:0]      win_x0,
    input  logic [CNT_W-1:0]      win_x1,
    input  logic [CNT_W-1:0]      win_y0,
    input  logic [CNT_W-1:0]      win_y1,
    input  logic [2*SAMPLE_W-1:0] din,
    input  logic                  hsync_in,
    input  logic                  vsync_in,
    input  logic                  act_in,
    output logic                  pix_valid,
    output logic [SAMPLE_W-1:0]   pix_y0,
    output logic [SAMPLE_W-1:0]   pix_y1,
    output logic [SAMPLE_W-1:0]   pix_cb,
    output logic [SAMPLE_W-1:0]   pix_cr,
    output logic                  pix_sof,
    output logic                  pix_eol
);

    logic             word_act;
    logic             vblank;
    logic             pair_stb;
    pix_pair_t        pair;
    pix_pair_t        out_pair;
    logic [CNT_W-1:0] px;
    logic [CNT_W-1:0] ln;

    vcap_sync_recover #(.W(SAMPLE_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (sync_mode),
        .lane   (din[SAMPLE_W-1:0]),
        .hsync  (hsync_in),
        .vsync  (vsync_in),
        .qual   (act_in),
        .act    (word_act),
        .vblank (vblank)
    );

    vcap_pair_assembler #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_bus),
        .act      (word_act),
        .vblank   (vblank),
        .din      (din),
        .pair_stb (pair_stb),
        .pair     (pair),
        .px       (px),
        .ln       (ln)
    );

    vcap_window #(.CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_stb  (pair_stb),
        .pair      (pair),
        .px        (px),
        .ln        (ln),
        .vblank    (vblank),
        .x0        (win_x0),
        .x1        (win_x1),
        .y0        (win_y0),
        .y1        (win_y1),
        .out_valid (pix_valid),
        .out_pair  (out_pair),
        .out_sof   (pix_sof),
        .out_eol   (pix_eol)
    );

    assign pix_y0 = out_pair.y0;
    assign pix_y1 = out_pair.y1;
    assign pix_cb = out_pair.cb;
    assign pix_cr = out_pair.cr;

endmodule

// File: rtl/vcap_checker.sv
// Checker: temporal properties on the output stream of the capture
// front-end, attached to every instance of the top by bind.
module vcap_checker (
    input logic clk,
    input logic rst_n,
    input logic pix_valid,
    input logic pix_sof,
    input logic pix_eol
);

    // R1: outputs are clear in the cycle after any reset cycle
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && !pix_sof && !pix_eol));

    // R10: start-of-field only accompanies a presented pair
    assert_sof_with_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |-> pix_valid);

    // R11: end-of-line only accompanies a presented pair
    assert_eol_with_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol |-> pix_valid);

    // R12: a pair is presented for one cycle, never back to back
    assert_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

endmodule

bind vid_capture_frontend vcap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_eol   (pix_eol)
);

// File: tb/sim_vid_capture_frontend.sv
module sim_vid_capture_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int MAXQ = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sync_mode = 2'd0;
    logic        wide_bus = 1'b0;
    logic [11:0] win_x0 = '0, win_x1 = '0, win_y0 = '0, win_y1 = '0;
    logic [15:0] din = 16'h1010;
    logic        hsync_in = 1'b1, vsync_in = 1'b0, act_in = 1'b0;
    logic        pix_valid, pix_sof, pix_eol;
    logic [7:0]  pix_y0, pix_y1, pix_cb, pix_cr;

    int checks = 0;
    int errors = 0;
    int b2b = 0;
    bit done = 0;
    bit last_valid = 0;

    logic [33:0] got_q [MAXQ];
    logic [33:0] exp_q [MAXQ];
    int n_got = 0;
    int n_exp = 0;

    vid_capture_frontend u0 (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .wide_bus(wide_bus),
        .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
        .din(din), .hsync_in(hsync_in), .vsync_in(vsync_in), .act_in(act_in),
        .pix_valid(pix_valid), .pix_y0(pix_y0), .pix_y1(pix_y1),
        .pix_cb(pix_cb), .pix_cr(pix_cr), .pix_sof(pix_sof), .pix_eol(pix_eol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // capture every presented pair just after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (pix_valid && last_valid) b2b++;
            if (pix_valid && n_got < MAXQ) begin
                got_q[n_got] = {pix_sof, pix_eol, pix_y0, pix_y1, pix_cb, pix_cr};
                n_got++;
            end
        end
        last_valid = pix_valid;
    end

    function automatic logic [7:0] ygen(int l, int p);
        return 8'(32 + l*8 + p);
    endfunction
    function automatic logic [7:0] cbgen(int l, int q);
        return 8'(64 + l*4 + q);
    endfunction
    function automatic logic [7:0] crgen(int l, int q);
        return 8'(128 + l*4 + q);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
        end
    endtask

    task automatic put(input logic [15:0] d, input logic h, input logic v, input logic e);
        @(negedge clk);
        din = d; hsync_in = h; vsync_in = v; act_in = e;
    endtask

    task automatic idle();
        put(16'h1010, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic code(input logic [7:0] xy);
        put(16'h80FF, 1'b0, 1'b0, 1'b0);
        put(16'h8000, 1'b0, 1'b0, 1'b0);
        put(16'h8000, 1'b0, 1'b0, 1'b0);
        put({8'h80, xy}, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_pixels(input int l, input int npix);
        logic h;
        h = (sync_mode == 2'd1);   // qualifier mode: hsync held high, must be ignored (R5)
        for (int q = 0; q < npix/2; q++) begin
            if (wide_bus) begin
                put({cbgen(l,q), ygen(l,2*q)}, h, 1'b0, 1'b1);
                put({crgen(l,q), ygen(l,2*q+1)}, h, 1'b0, 1'b1);
            end else begin
                put({8'h00, cbgen(l,q)}, h, 1'b0, 1'b1);
                put({8'h00, ygen(l,2*q)}, h, 1'b0, 1'b1);
                put({8'h00, crgen(l,q)}, h, 1'b0, 1'b1);
                put({8'h00, ygen(l,2*q+1)}, h, 1'b0, 1'b1);
            end
        end
    endtask

    task automatic field_start(input int npix);
        if (sync_mode == 2'd2) begin
            code(8'hB0);               // V=1 H=1: field blanking (R7)
            idle();
            code(8'hA0);               // V=1 H=0: must not open active video (R7)
            send_pixels(7, npix);
            code(8'hB0);
            idle();
        end else begin
            for (int i = 0; i < 3; i++) put(16'h1010, 1'b1, 1'b1, 1'b1);
            idle();
        end
    endtask

    task automatic send_line(input int l, input int npix);
        if (sync_mode == 2'd2) begin
            code(8'h80);               // start of active video (R6)
            send_pixels(l, npix);
            code(8'h90);               // end of active video
            idle();
        end else begin
            idle(); idle();
            send_pixels(l, npix);
            idle();
        end
    endtask

    // one scenario: a field in the given mode, compared against the window model
    task automatic run_field(input string tag, input logic [1:0] m, input logic w,
                             input int nl, input int npix,
                             input int ax0, input int ax1, input int ay0, input int ay1);
        bit first;
        int x0e;
        @(negedge clk);
        sync_mode = m; wide_bus = w;
        win_x0 = 12'(ax0); win_x1 = 12'(ax1); win_y0 = 12'(ay0); win_y1 = 12'(ay1);
        n_got = 0; n_exp = 0; first = 1;
        x0e = ax0 & ~1;
        for (int l = 0; l < nl; l++) begin
            for (int q = 0; q < npix/2; q++) begin
                if (2*q >= x0e && 2*q < ax1 && l >= ay0 && l < ay1) begin
                    exp_q[n_exp] = {first, (2*q+2 >= ax1), ygen(l,2*q), ygen(l,2*q+1),
                                    cbgen(l,q), crgen(l,q)};
                    n_exp++;
                    first = 0;
                end
            end
        end
        field_start(npix);
        for (int l = 0; l < nl; l++) send_line(l, npix);
        idle(); idle(); idle();
        check(n_got == n_exp, {tag, " pair count"}, 64'(n_got), 64'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(got_q[i] == exp_q[i], {tag, " pair contents/markers"},
                  64'(got_q[i]), 64'(exp_q[i]));
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        sync_mode = 2'd0; wide_bus = 1'b1;
        win_x0 = 0; win_x1 = 100; win_y0 = 0; win_y1 = 100;
        for (int i = 0; i < 4; i++) begin
            put(16'h4020, 1'b0, 1'b0, 1'b1);
            @(posedge clk); #2;
            check(!pix_valid && !pix_sof && !pix_eol, "R1 outputs clear in reset",
                  64'({pix_valid, pix_sof, pix_eol}), 64'd0);
        end
        put(16'h1010, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(!pix_valid, "R1 first cycle after reset", 64'(pix_valid), 64'd0);
    endtask

    task automatic test_timing();
        @(negedge clk);
        sync_mode = 2'd0; wide_bus = 1'b1;
        win_x0 = 0; win_x1 = 4000; win_y0 = 0; win_y1 = 4000;
        field_start(4);
        put({8'h51, 8'h31}, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #2;
        check(!pix_valid, "R12 not due after first word", 64'(pix_valid), 64'd0);
        put({8'h61, 8'h32}, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #2;
        check(pix_valid && pix_y0 == 8'h31 && pix_y1 == 8'h32 && pix_cb == 8'h51 && pix_cr == 8'h61,
              "R12 pair due after second word", 64'({pix_valid, pix_y0, pix_y1, pix_cb, pix_cr}),
              64'({1'b1, 32'h31325161}));
        idle();
        @(posedge clk); #2;
        check(!pix_valid, "R12 single-cycle presentation", 64'(pix_valid), 64'd0);
        idle(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        // R2 R4 R10 R11: narrow bus, sync levels, full-width window
        run_field("R2/R4 narrow levels", 2'd0, 1'b0, 3, 8, 0, 8, 0, 3);
        // R3 R5 R8 R9: wide bus, qualifier, odd left edge, cropped lines
        run_field("R3/R5/R8/R9 wide qualifier", 2'd1, 1'b1, 4, 10, 3, 7, 1, 3);
        // R6 R7: narrow bus, embedded codes, cropped columns
        run_field("R6/R7 narrow codes", 2'd2, 1'b0, 3, 8, 2, 6, 0, 2);
        // R6 R3: wide bus, embedded codes
        run_field("R6 wide codes", 2'd2, 1'b1, 3, 6, 0, 6, 0, 4);
        // R10: second field re-arms start-of-field
        run_field("R10 second field", 2'd0, 1'b0, 2, 6, 0, 4, 1, 2);
        // R9: window below the field yields nothing
        run_field("R9 empty window", 2'd1, 1'b0, 2, 6, 0, 6, 5, 9);
        test_timing();
        check(b2b == 0, "R12 no back-to-back pairs", 64'(b2b), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule